// File: doc/BRIEF.md
# PHY Configuration Test-Port Slave

This block is the PHY-side end of a byte-wide configuration port. A controller drives a slow strobe clock, an enable line, a clear line and an 8-bit data bus. The block keeps a small set of control bytes: a mode byte, a clock-lane control byte, one control byte per data lane and a settle-time threshold. These bytes are always visible as outputs to the receive circuits. The block also returns one byte on a readback bus.

A transfer has two halves. The controller leaves the strobe high when idle. It places a register code on the bus, raises enable and drops the strobe: that falling edge captures the code. It then lowers enable, places the data byte on the bus and raises the strobe: that rising edge stores the data in the register the code selects. All port lines are brought into the system clock domain through two flip-flops before any edge is detected. For this reason a strobe level must be held for several system clocks.

Top module: `phy_tport`

## Requirements
- R1: After system reset, every control output and the readback bus are zero.
- R2: A falling strobe edge sampled with enable high captures the data bus as the current register code.
- R3: A rising strobe edge sampled with enable low stores the data bus in the register selected by the current code. The codes are 0x00 for mode, 0x34 for clock lane, 0x75 for settle, and 0x44, 0x54, 0x84, 0x94 for data lanes 0 to 3. Lane n drives bits [8n+7:8n] of the lane output.
- R4: A rising strobe edge sampled with enable still high writes nothing.
- R5: A falling strobe edge sampled with enable low leaves the current code unchanged.
- R6: While the clear line is high, the code and all control registers are held at zero, and strobe edges have no effect.
- R7: A write under a code outside the implemented set changes no output, and the readback bus reads zero while such a code is selected.
- R8: The readback bus always shows the register selected by the current code.
- R9: After the strobe rises, a write appears at the outputs on the third rising system-clock edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_i | input | 1 | Port strobe clock, idles high |
| cfg_en_i | input | 1 | Port enable: high for the code phase |
| cfg_clr_i | input | 1 | Port clear, active high |
| cfg_din_i | input | 8 | Code or data byte |
| cfg_dout_o | output | 8 | Readback of the selected register |
| mode_o | output | 8 | Mode byte (code 0x00) |
| clane_ctl_o | output | 8 | Clock-lane control byte (code 0x34) |
| dlane_ctl_o | output | 8*LANES | Data-lane control bytes, lane 0 in the low byte |
| settle_o | output | 8 | Settle-time threshold (code 0x75) |

## Verification
A corrupted code register shows up on the readback bus as soon as the code is latched. A wrong decode sends a data byte to the wrong control output within three system clocks of the strobe rising. Every one of the 256 codes is written and the full output set is compared with a model after each write. Any write that goes astray is therefore seen at the transfer that caused it. Missed clears, writes taken with enable high and codes captured with enable low each leave a stale byte on some output. The bench compares that byte right after the stimulus.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] CODE_MODE   = 8'h00;
  localparam logic [7:0] CODE_CLANE  = 8'h34;
  localparam logic [7:0] CODE_SETTLE = 8'h75;

  // Register code of data lane idx
  function automatic logic [7:0] lane_code(input int idx);
    case (idx)
      0:       lane_code = 8'h44;
      1:       lane_code = 8'h54;
      2:       lane_code = 8'h84;
      default: lane_code = 8'h94;
    endcase
  endfunction

  // True when code selects one of the first lanes data lanes
  function automatic logic is_lane_code(input logic [7:0] code, input int lanes);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < lanes; i++) begin
      if (code == lane_code(i)) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/phy_tport_sync.sv
module phy_tport_sync #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/phy_tport_edge.sv
module phy_tport_edge #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/phy_tport_regs.sv
module phy_tport_regs
  import phy_tport_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW   = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              latch_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] code_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] clane_o,
  output logic [LW-1:0]     lane_o,
  output logic [BYTE_W-1:0] settle_o,
  output logic [BYTE_W-1:0] rd_o
);
  logic [BYTE_W-1:0] code_q;
  logic [BYTE_W-1:0] mode_q;
  logic [BYTE_W-1:0] clane_q;
  logic [BYTE_W-1:0] settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (clr_i)   code_q <= '0;
    else if (latch_i) code_q <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      clane_q  <= '0;
      settle_q <= '0;
    end else if (clr_i) begin
      mode_q   <= '0;
      clane_q  <= '0;
      settle_q <= '0;
    end else if (wr_i) begin
      if (code_q == CODE_MODE)   mode_q   <= din_i;
      if (code_q == CODE_CLANE)  clane_q  <= din_i;
      if (code_q == CODE_SETTLE) settle_q <= din_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (clr_i)                            q <= '0;
      else if (wr_i && code_q == lane_code(g))   q <= din_i;
    end
    assign lane_o[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_o = '0;
    if (code_q == CODE_MODE)   rd_o = mode_q;
    if (code_q == CODE_CLANE)  rd_o = clane_q;
    if (code_q == CODE_SETTLE) rd_o = settle_q;
    for (int i = 0; i < LANES; i++) begin
      if (code_q == lane_code(i)) rd_o = lane_o[i*BYTE_W +: BYTE_W];
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign clane_o  = clane_q;
  assign settle_o = settle_q;
endmodule

// File: rtl/phy_tport.sv
module phy_tport
  import phy_tport_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_clk_i,
  input  logic                    cfg_en_i,
  input  logic                    cfg_clr_i,
  input  logic [7:0]              cfg_din_i,
  output logic [7:0]              cfg_dout_o,
  output logic [7:0]              mode_o,
  output logic [7:0]              clane_ctl_o,
  output logic [LANES*8-1:0]      dlane_ctl_o,
  output logic [7:0]              settle_o
);
  localparam int SW = BYTE_W + 3;
  // strobe synchroniser resets to the idle-high level
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {BYTE_W{1'b0}}};

  logic [SW-1:0]     sync_q;
  logic              tclk_s;
  logic              ten_s;
  logic              tclr_s;
  logic [BYTE_W-1:0] tdin_s;
  logic              tclk_rise;
  logic              tclk_fall;
  logic              code_latch;
  logic              data_wr;
  logic [BYTE_W-1:0] cur_code;

  phy_tport_sync #(.W(SW), .RST_VAL(SYNC_RST)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cfg_clr_i, cfg_en_i, cfg_clk_i, cfg_din_i}),
    .q_o   (sync_q)
  );

  assign tdin_s = sync_q[BYTE_W-1:0];
  assign tclk_s = sync_q[BYTE_W];
  assign ten_s  = sync_q[BYTE_W+1];
  assign tclr_s = sync_q[BYTE_W+2];

  phy_tport_edge #(.RST_LVL(1'b1)) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (tclk_s),
    .rise_o (tclk_rise),
    .fall_o (tclk_fall)
  );

  assign code_latch = tclk_fall & ten_s & ~tclr_s;
  assign data_wr    = tclk_rise & ~ten_s & ~tclr_s;

  phy_tport_regs #(.LANES(LANES)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tclr_s),
    .latch_i  (code_latch),
    .wr_i     (data_wr),
    .din_i    (tdin_s),
    .code_o   (cur_code),
    .mode_o   (mode_o),
    .clane_o  (clane_ctl_o),
    .lane_o   (dlane_ctl_o),
    .settle_o (settle_o),
    .rd_o     (cfg_dout_o)
  );
endmodule

// File: rtl/phy_tport_chk.sv
module phy_tport_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rise,
  input logic               fall,
  input logic               en,
  input logic               clr,
  input logic [7:0]         din,
  input logic [7:0]         code,
  input logic [7:0]         dout,
  input logic [7:0]         mode,
  input logic [7:0]         clane,
  input logic [LANES*8-1:0] lanes,
  input logic [7:0]         settle
);
  logic known;
  always_comb begin
    known = (code == 8'h00) || (code == 8'h34) || (code == 8'h75);
    for (int i = 0; i < LANES; i++) begin
      if (code == phy_tport_pkg::lane_code(i)) known = 1'b1;
    end
  end

  AST_CODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && en && !clr) |=> code == $past(din)); // R2
  AST_SETTLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !en && !clr && code == 8'h75) |=> settle == $past(din)); // R3
  AST_NO_WRITE_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en && !clr) |=> $stable({mode, clane, lanes, settle})); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fall && en) && !clr) |=> $stable(code)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code == 8'h00 && mode == 8'h00 && clane == 8'h00 && settle == 8'h00 && lanes == '0)); // R6
  AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> dout == 8'h00); // R7
endmodule

bind phy_tport phy_tport_chk #(.LANES(LANES)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .rise   (tclk_rise),
  .fall   (tclk_fall),
  .en     (ten_s),
  .clr    (tclr_s),
  .din    (tdin_s),
  .code   (cur_code),
  .dout   (cfg_dout_o),
  .mode   (mode_o),
  .clane  (clane_ctl_o),
  .lanes  (dlane_ctl_o),
  .settle (settle_o)
);

// File: tb/phy_tport_tb_top.sv
`timescale 1ns/1ps
module phy_tport_tb_top;
  localparam int LANES = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_clk = 1'b1;
  logic               cfg_en = 1'b0;
  logic               cfg_clr = 1'b0;
  logic [7:0]         cfg_din = 8'h00;
  logic [7:0]         cfg_dout;
  logic [7:0]         mode;
  logic [7:0]         clane;
  logic [LANES*8-1:0] dlanes;
  logic [7:0]         settle;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] mdl [256];
  logic [7:0] cur;

  always #4 clk = ~clk;

  phy_tport #(.LANES(LANES)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_clk_i   (cfg_clk),
    .cfg_en_i    (cfg_en),
    .cfg_clr_i   (cfg_clr),
    .cfg_din_i   (cfg_din),
    .cfg_dout_o  (cfg_dout),
    .mode_o      (mode),
    .clane_ctl_o (clane),
    .dlane_ctl_o (dlanes),
    .settle_o    (settle)
  );

  function automatic bit bimpl(input logic [7:0] c);
    return c == 8'h00 || c == 8'h34 || c == 8'h75 ||
           c == 8'h44 || c == 8'h54 || c == 8'h84 || c == 8'h94;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk({req, " mode"},   {24'd0, mode},   {24'd0, mdl[8'h00]});
    chk({req, " clane"},  {24'd0, clane},  {24'd0, mdl[8'h34]});
    chk({req, " settle"}, {24'd0, settle}, {24'd0, mdl[8'h75]});
    chk({req, " lanes"},  dlanes, {mdl[8'h94], mdl[8'h84], mdl[8'h54], mdl[8'h44]});
    chk({req, " R8 dout"}, {24'd0, cfg_dout}, {24'd0, bimpl(cur) ? mdl[cur] : 8'h00});
  endtask

  task automatic phy_write(input logic [7:0] c, input logic [7:0] d);
    cfg_din = c; wt(4);
    cfg_en = 1'b1; wt(4);
    cfg_clk = 1'b0; wt(4);
    cfg_en = 1'b0; cfg_din = d; wt(4);
    cfg_clk = 1'b1; wt(5);
  endtask

  // select a code without writing: strobe rises while enable is high
  task automatic phy_sel(input logic [7:0] c);
    cfg_din = c; cfg_en = 1'b1; wt(4);
    cfg_clk = 1'b0; wt(4);
    cfg_clk = 1'b1; wt(4);
    cfg_en = 1'b0; wt(4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    cur = 8'h00;
    wt(3);
    rst_n = 1'b1;
    wt(5);
    check_all("R1 reset");

    // R3 / R7: write every code, compare every output with the model
    for (int c = 0; c < 256; c++) begin
      logic [7:0] d;
      d = 8'((c * 37 + 11) & 8'hFF);
      phy_write(8'(c), d);
      cur = 8'(c);
      if (bimpl(8'(c))) mdl[c] = d;
      check_all(bimpl(8'(c)) ? "R3 write" : "R7 unknown");
    end

    // R8 / R2: select each code without writing and read it back
    for (int c = 0; c < 256; c += 3) begin
      phy_sel(8'(c));
      cur = 8'(c);
      check_all("R2 select");
    end

    // R4: rising strobe with enable still high must not write
    phy_sel(8'h75);
    cur = 8'h75;
    cfg_din = 8'h75; cfg_en = 1'b1; wt(4);
    cfg_clk = 1'b0; wt(4);
    cfg_din = 8'hEE; wt(4);
    cfg_clk = 1'b1; wt(5);
    cfg_en = 1'b0; wt(4);
    check_all("R4 en-high rise");

    // R5: falling strobe with enable low keeps the code; the next rise writes settle
    cfg_din = 8'h34; wt(4);
    cfg_clk = 1'b0; wt(4);
    cfg_clk = 1'b1; wt(5);
    mdl[8'h75] = 8'h34;
    check_all("R5 code held");

    // R9: latency of a write after the strobe rises
    cfg_din = 8'h75; cfg_en = 1'b1; wt(4);
    cfg_clk = 1'b0; wt(4);
    cfg_en = 1'b0; cfg_din = 8'h5A; wt(4);
    cfg_clk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 early", {24'd0, settle}, 32'h34);
    @(posedge clk); #1;
    chk("R9 on time", {24'd0, settle}, 32'h5A);
    mdl[8'h75] = 8'h5A;
    wt(4);

    // R6: clear zeroes everything and blocks writes while high
    phy_write(8'h44, 8'hC3);
    mdl[8'h44] = 8'hC3; cur = 8'h44;
    check_all("R3 lane0");
    cfg_clr = 1'b1; wt(5);
    phy_write(8'h54, 8'h77);
    cfg_clr = 1'b0; wt(5);
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    cur = 8'h00;
    check_all("R6 clear");
    phy_sel(8'h54);
    cur = 8'h54;
    check_all("R6 no write in clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule